// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Request Logic

This block keeps the four status flags of an SPI peripheral for a small 8-bit microcontroller. The flags are transmit-empty, receive-full, overrun and mode-fault. From them it derives two CPU interrupt requests: one for the transmitter, and one that the receiver and the error sources share. The serial shift engine reports byte movements and error events as single-cycle strobes. The CPU register interface reports reads of the status and data registers, and writes to the data and control registers, also as single-cycle strobes. The control enables arrive as level inputs.

A flag that software clears by reading needs a two-step sequence. First a status read must observe the flag set. Then the matching register access clears it. That access is a data read for receive-full and overrun, and a control write for mode-fault. A one-bit armed register per flag records the first step. A fresh set event drops the armed bit, so a byte that arrives between the two reads is never lost silently. Transmit-empty clears on any data write.

Top module: `spi_flag_irq`

## Requirements
- R1: After reset, txEmpty is 1, rxFull, overrun and modeFault are 0, and txIrq and rxErrIrq are 0.
- R2: A pulse on xferToRx sets rxFull on the next clock edge.
- R3: A data read clears rxFull only if an earlier status read saw rxFull set. A data read with no such status read leaves rxFull at 1.
- R4: An xferToRx that falls between the arming status read and the data read cancels the arming, so that data read leaves rxFull at 1.
- R5: A pulse on xferToShift sets txEmpty. Only a pulse on wrData clears it.
- R6: If a flag's set event and its clear event occur in the same cycle, the flag is 1 afterwards.
- R7: txIrq is registered. On each edge it takes the value txEmpty AND enTxIrq AND enSpi from the cycle before.
- R8: rxErrIrq is 1 one cycle after rxFull and enRxIrq are both 1, whatever the value of enSpi.
- R9: When enErrIrq is 1, overrun or modeFault raises rxErrIrq one cycle later.
- R10: While enModeFault is 0, a modeFaultEvt pulse leaves modeFault at 0.
- R11: overrun clears after a status read that saw it set followed by a data read. modeFault clears after a status read that saw it set followed by a wrCtrl pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xferToShift | input | 1 | Transmit byte moved into the shift register |
| xferToRx | input | 1 | Received byte moved into the receive data register |
| overrunEvt | input | 1 | Overrun event from the shift engine |
| modeFaultEvt | input | 1 | Mode-fault event from the shift engine |
| rdStatus | input | 1 | CPU read of the status/control register |
| rdData | input | 1 | CPU read of the receive data register |
| wrData | input | 1 | CPU write of the transmit data register |
| wrCtrl | input | 1 | CPU write of the control register |
| enSpi | input | 1 | Peripheral enable |
| enTxIrq | input | 1 | Transmit interrupt enable |
| enRxIrq | input | 1 | Receive interrupt enable |
| enErrIrq | input | 1 | Error interrupt enable |
| enModeFault | input | 1 | Allows the mode-fault flag to be set |
| txEmpty | output | 1 | Transmit-empty flag |
| rxFull | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| modeFault | output | 1 | Mode-fault flag |
| txIrq | output | 1 | Transmitter interrupt request |
| rxErrIrq | output | 1 | Shared receiver/error interrupt request |

## Verification
The assertions check the single-cycle relations on every cycle:
- a set strobe is followed by its flag,
- transmit-empty and receive-full hold when their clearing access is absent,
- mode-fault stays at 0 while it is disabled,
- the two request lines follow their flags and enables one cycle later.

The two-step clearing depends on a history of several accesses, so only the bench scenarios show it. They cover clearing after a status read, a data read with no arming status read, a new byte arriving between the two reads, and a set that collides with a clear.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int NumFlags = 4;
  localparam int FlagTx   = 0;
  localparam int FlagRx   = 1;
  localparam int FlagOvr  = 2;
  localparam int FlagMdf  = 3;
  localparam logic [NumFlags-1:0] FlagRstVal = 4'b0001;

  typedef struct packed {
    logic [NumFlags-1:0] setVec;
    logic [NumFlags-1:0] clrVec;
  } flagStrobe_t;
endpackage

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                xferToShift,
  input  logic                xferToRx,
  input  logic                overrunEvt,
  input  logic                modeFaultEvt,
  input  logic                rdStatus,
  input  logic                rdData,
  input  logic                wrData,
  input  logic                wrCtrl,
  input  logic                enModeFault,
  input  logic [NumFlags-1:0] flagQ,
  output flagStrobe_t         strobe
);
  localparam int NumArmed = NumFlags - 1;

  logic [NumFlags-1:0] clrAccess;
  logic [NumArmed-1:0] armedQ;

  // Set events straight from the shift engine; mode fault gated by its enable.
  assign strobe.setVec[FlagTx]  = xferToShift;
  assign strobe.setVec[FlagRx]  = xferToRx;
  assign strobe.setVec[FlagOvr] = overrunEvt;
  assign strobe.setVec[FlagMdf] = modeFaultEvt & enModeFault;

  // Register access that completes the clear sequence for each flag.
  assign clrAccess[FlagTx]  = wrData;
  assign clrAccess[FlagRx]  = rdData;
  assign clrAccess[FlagOvr] = rdData;
  assign clrAccess[FlagMdf] = wrCtrl;

  assign strobe.clrVec[FlagTx] = clrAccess[FlagTx];

  genvar g;
  generate
    for (g = 1; g < NumFlags; g++) begin : gArm
      assign strobe.clrVec[g] = armedQ[g-1] & clrAccess[g];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                     armedQ[g-1] <= 1'b0;
        else if (strobe.setVec[g])     armedQ[g-1] <= 1'b0;
        else if (rdStatus && flagQ[g]) armedQ[g-1] <= 1'b1;
        else if (clrAccess[g])         armedQ[g-1] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_flag_dp.sv
module spi_flag_dp
  import spi_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  flagStrobe_t         strobe,
  input  logic                enSpi,
  input  logic                enTxIrq,
  input  logic                enRxIrq,
  input  logic                enErrIrq,
  output logic [NumFlags-1:0] flagQ,
  output logic                txIrq,
  output logic                rxErrIrq
);
  genvar g;
  generate
    for (g = 0; g < NumFlags; g++) begin : gFlag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 flagQ[g] <= FlagRstVal[g];
        else if (strobe.setVec[g]) flagQ[g] <= 1'b1;
        else if (strobe.clrVec[g]) flagQ[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq    <= 1'b0;
      rxErrIrq <= 1'b0;
    end else begin
      txIrq    <= flagQ[FlagTx] & enTxIrq & enSpi;
      rxErrIrq <= (flagQ[FlagRx] & enRxIrq) |
                  (enErrIrq & (flagQ[FlagOvr] | flagQ[FlagMdf]));
    end
  end
endmodule

// File: rtl/spi_flag_irq.sv
module spi_flag_irq
  import spi_flag_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic xferToShift,
  input  logic xferToRx,
  input  logic overrunEvt,
  input  logic modeFaultEvt,
  input  logic rdStatus,
  input  logic rdData,
  input  logic wrData,
  input  logic wrCtrl,
  input  logic enSpi,
  input  logic enTxIrq,
  input  logic enRxIrq,
  input  logic enErrIrq,
  input  logic enModeFault,
  output logic txEmpty,
  output logic rxFull,
  output logic overrun,
  output logic modeFault,
  output logic txIrq,
  output logic rxErrIrq
);
  flagStrobe_t         strobe;
  logic [NumFlags-1:0] flagQ;

  spi_flag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .xferToShift(xferToShift), .xferToRx(xferToRx),
    .overrunEvt(overrunEvt), .modeFaultEvt(modeFaultEvt),
    .rdStatus(rdStatus), .rdData(rdData), .wrData(wrData), .wrCtrl(wrCtrl),
    .enModeFault(enModeFault), .flagQ(flagQ), .strobe(strobe)
  );

  spi_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .enSpi(enSpi), .enTxIrq(enTxIrq), .enRxIrq(enRxIrq), .enErrIrq(enErrIrq),
    .flagQ(flagQ), .txIrq(txIrq), .rxErrIrq(rxErrIrq)
  );

  assign txEmpty   = flagQ[FlagTx];
  assign rxFull    = flagQ[FlagRx];
  assign overrun   = flagQ[FlagOvr];
  assign modeFault = flagQ[FlagMdf];
endmodule

// File: rtl/spi_flag_irq_chk.sv
module spi_flag_irq_chk (
  input logic clk,
  input logic rstN,
  input logic xferToShift,
  input logic xferToRx,
  input logic modeFaultEvt,
  input logic wrData,
  input logic rdData,
  input logic enSpi,
  input logic enTxIrq,
  input logic enRxIrq,
  input logic enErrIrq,
  input logic enModeFault,
  input logic txEmpty,
  input logic rxFull,
  input logic overrun,
  input logic modeFault,
  input logic txIrq,
  input logic rxErrIrq
);
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rstN) xferToRx |=> rxFull); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN) (rxFull && !rdData) |=> rxFull); // R3
  AST_TX_SET: assert property (@(posedge clk) disable iff (!rstN) xferToShift |=> txEmpty); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN) (txEmpty && !wrData) |=> txEmpty); // R5
  AST_TX_CLR: assert property (@(posedge clk) disable iff (!rstN) (wrData && !xferToShift) |=> !txEmpty); // R5
  AST_TXIRQ_OFF: assert property (@(posedge clk) disable iff (!rstN) !enSpi |=> !txIrq); // R7
  AST_TXIRQ_ON: assert property (@(posedge clk) disable iff (!rstN) (txEmpty && enTxIrq && enSpi) |=> txIrq); // R7
  AST_RXIRQ_ON: assert property (@(posedge clk) disable iff (!rstN) (rxFull && enRxIrq) |=> rxErrIrq); // R8
  AST_ERRIRQ_ON: assert property (@(posedge clk) disable iff (!rstN) (enErrIrq && (overrun || modeFault)) |=> rxErrIrq); // R9
  AST_MDF_BLOCK: assert property (@(posedge clk) disable iff (!rstN) (!enModeFault && !modeFault) |=> !modeFault); // R10
  AST_MDF_SET: assert property (@(posedge clk) disable iff (!rstN) (enModeFault && modeFaultEvt) |=> modeFault); // R6
endmodule

bind spi_flag_irq spi_flag_irq_chk u_chk (.*);

// File: tb/sim_spi_flag_irq.sv
`timescale 1ns/1ps
module sim_spi_flag_irq;
  localparam int BXS = 0, BXR = 1, BOV = 2, BMF = 3, BRS = 4, BRD = 5, BWD = 6, BWC = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] stim = '0;
  logic enSpi = 0, enTxIrq = 0, enRxIrq = 0, enErrIrq = 0, enModeFault = 0;
  logic txEmpty, rxFull, overrun, modeFault, txIrq, rxErrIrq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  spi_flag_irq u0 (
    .clk(clk), .rstN(rstN),
    .xferToShift(stim[BXS]), .xferToRx(stim[BXR]), .overrunEvt(stim[BOV]),
    .modeFaultEvt(stim[BMF]), .rdStatus(stim[BRS]), .rdData(stim[BRD]),
    .wrData(stim[BWD]), .wrCtrl(stim[BWC]),
    .enSpi(enSpi), .enTxIrq(enTxIrq), .enRxIrq(enRxIrq), .enErrIrq(enErrIrq),
    .enModeFault(enModeFault),
    .txEmpty(txEmpty), .rxFull(rxFull), .overrun(overrun), .modeFault(modeFault),
    .txIrq(txIrq), .rxErrIrq(rxErrIrq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive strobes for one cycle starting at a falling edge; results visible at the next falling edge.
  task automatic pulse(input logic [7:0] m);
    stim = m;
    @(negedge clk);
    stim = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 txEmpty", txEmpty, 1'b1);
    chk("R1 rxFull", rxFull, 1'b0);
    chk("R1 overrun", overrun, 1'b0);
    chk("R1 modeFault", modeFault, 1'b0);
    chk("R1 txIrq", txIrq, 1'b0);
    chk("R1 rxErrIrq", rxErrIrq, 1'b0);
  endtask

  task automatic t_tx();
    pulse(8'(1 << BWD));
    chk("R5 clear by write", txEmpty, 1'b0);
    step();
    chk("R5 stays clear", txEmpty, 1'b0);
    pulse(8'(1 << BXS));
    chk("R5 set by transfer", txEmpty, 1'b1);
    pulse(8'(1 << BRS) | 8'(1 << BRD) | 8'(1 << BWC));
    chk("R5 other accesses ignored", txEmpty, 1'b1);
    pulse(8'(1 << BWD) | 8'(1 << BXS));
    chk("R6 tx set wins", txEmpty, 1'b1);
  endtask

  task automatic t_rx();
    pulse(8'(1 << BXR));
    chk("R2 rxFull set", rxFull, 1'b1);
    pulse(8'(1 << BRD));
    chk("R3 data read alone", rxFull, 1'b1);
    pulse(8'(1 << BRS));
    pulse(8'(1 << BRD));
    chk("R3 two-step clear", rxFull, 1'b0);
    pulse(8'(1 << BXR));
    pulse(8'(1 << BRS));
    pulse(8'(1 << BXR));
    pulse(8'(1 << BRD));
    chk("R4 new byte cancels arming", rxFull, 1'b1);
    pulse(8'(1 << BRS));
    pulse(8'(1 << BRD) | 8'(1 << BXR));
    chk("R6 rx set wins", rxFull, 1'b1);
    pulse(8'(1 << BRS));
    pulse(8'(1 << BRD));
    chk("R3 clear after rearm", rxFull, 1'b0);
  endtask

  task automatic t_irq();
    enTxIrq = 1; enSpi = 0;
    step(); step();
    chk("R7 gated by enSpi", txIrq, 1'b0);
    enSpi = 1;
    step();
    chk("R7 tx request", txIrq, 1'b1);
    pulse(8'(1 << BWD));
    step();
    chk("R7 tx request drops", txIrq, 1'b0);
    pulse(8'(1 << BXS));
    enSpi = 0; enTxIrq = 0;
    enRxIrq = 1;
    step();
    chk("R8 no request while empty", rxErrIrq, 1'b0);
    pulse(8'(1 << BXR));
    step();
    chk("R8 rx request without enSpi", rxErrIrq, 1'b1);
    pulse(8'(1 << BRS));
    pulse(8'(1 << BRD));
    step();
    chk("R8 rx request drops", rxErrIrq, 1'b0);
    enRxIrq = 0;
  endtask

  task automatic t_err();
    enErrIrq = 1; enModeFault = 0;
    pulse(8'(1 << BMF));
    chk("R10 mode fault blocked", modeFault, 1'b0);
    step();
    chk("R10 no error request", rxErrIrq, 1'b0);
    enModeFault = 1;
    pulse(8'(1 << BMF));
    chk("R6 mode fault set", modeFault, 1'b1);
    step();
    chk("R9 mode fault request", rxErrIrq, 1'b1);
    pulse(8'(1 << BWC));
    chk("R11 control write alone", modeFault, 1'b1);
    pulse(8'(1 << BRS));
    pulse(8'(1 << BWC));
    chk("R11 mode fault cleared", modeFault, 1'b0);
    pulse(8'(1 << BOV));
    chk("R9 overrun set", overrun, 1'b1);
    step();
    chk("R9 overrun request", rxErrIrq, 1'b1);
    pulse(8'(1 << BRD));
    chk("R11 data read alone", overrun, 1'b1);
    pulse(8'(1 << BRS));
    pulse(8'(1 << BRD));
    chk("R11 overrun cleared", overrun, 1'b0);
    step();
    chk("R9 request drops", rxErrIrq, 1'b0);
    enErrIrq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    step();
    t_reset();
    t_tx();
    t_rx();
    t_irq();
    t_err();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule